// File: doc/BRIEF.md
# Multiplexed Bus Target Data-Phase Controller

This block is the responding side of a shared, multiplexed address/data bus with active-low control lines. When the initiator opens a transaction, the block samples the address and the command in that first cycle and decides whether the transaction belongs to it. Two conditions must hold. The address must fall inside a power-of-two window, and the command must be a memory read or a memory write. If both hold, the block claims the bus by pulling its select line low. This happens one, two or three cycles after the address cycle, depending on a speed setting sampled with the address.

After the claim, the block runs one or more data phases. A word moves only on a clock edge where both the initiator's ready and the target's ready are low. The target's ready is gated by a wait input from the local side. Once the target's ready is asserted, it stays locked until the word moves. Reads are served from a simple local port, and writes are presented to that port in the cycle they complete. The burst address advances by four bytes on each completed phase. After the final phase, the block drives its control lines high for one cycle and then releases them.

Top module: `busTgtTop`

## Requirements
- R1: While reset is asserted and right after it, devselN and trdyN are high, devselOe, trdyOe and adOe are low, and locWrEn is low.
- R2: Speed code 0 puts devselN low in the first cycle after the address cycle. Code 1 puts it low in the second cycle, and codes 2 and 3 in the third. devselN then stays low through the final transfer cycle.
- R3: A transaction is claimed only for command 4'b0110 (read) or 4'b0111 (write), with adIn[31:8] equal to the upper bits of the base address. In particular, the dual-address command 4'b1101 is never answered, and neither is any other command or an address outside the window.
- R4: trdyN first goes low in the cycle after a cycle in which devselN is low and locWait is low. A word transfers only in a cycle where irdyN and trdyN are both low.
- R5: Once trdyN is low, it stays low until a transfer takes place, whatever locWait does in the meantime.
- R6: On reads, adOe is low in the cycle after the address cycle, which is the turnaround cycle. adOe is high whenever trdyN is low, and adOut then holds the local read data for the phase address. adOut does not change while the phase is stretched.
- R7: While both ready lines stay low, phases complete one per clock. Phase k of a burst uses address base + 4*k.
- R8: On writes, locWrEn is high exactly in the transfer cycles. In those cycles locAddr is the phase address, locWrData is adIn, and locBe is the inverse of cbeN.
- R9: The transfer with frameN high is the final one. In the next cycle, devselN and trdyN are high while devselOe and trdyOe are still high. In the cycle after that, both output enables are low.
- R10: While locWait is high and trdyN is high, trdyN stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devSpeed | input | 2 | Claim delay code sampled in the address cycle |
| adIn | input | 32 | Address/data bus as seen by the target |
| cbeN | input | 4 | Command in the address cycle, active-low byte enables in data phases |
| frameN | input | 1 | Initiator transaction line, high in the final phase |
| irdyN | input | 1 | Initiator ready, active low |
| adOut | output | 32 | Read data driven onto the bus |
| adOe | output | 1 | Output enable for adOut |
| devselN | output | 1 | Device select, active low |
| devselOe | output | 1 | Output enable for devselN |
| trdyN | output | 1 | Target ready, active low |
| trdyOe | output | 1 | Output enable for trdyN |
| locAddr | output | 32 | Local port word address |
| locWrData | output | 32 | Local write data |
| locBe | output | 4 | Local byte enables, active high |
| locWrEn | output | 1 | Local write strobe |
| locRdData | input | 32 | Local read data for locAddr, combinational |
| locWait | input | 1 | Local side not ready; holds off target ready |

## Verification
The assertions assume a well-behaved initiator. It keeps frameN low until the phase in which it asserts irdyN for the last time, and it does not withdraw irdyN before a transfer. They also assume that locRdData follows locAddr within the same cycle. The bench initiator drives its lines only at falling edges. It raises frameN only together with irdyN in the final phase and never withdraws irdyN early. The bench's local memory model is a pure function of locAddr, so read data is always ready in time. Late pulses on locWait are placed only while the target's ready is already locked and the initiator is still holding off, so a burst can never stall indefinitely.

// File: rtl/busTgtPkg.sv
package busTgtPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CLAIM, ST_DATA, ST_PARK} tgtState_e;

  typedef struct packed {
    logic latch;   // capture address and command
    logic inc;     // a word moved on this edge
    logic loadRd;  // load read data for the coming phase
    logic dropAd;  // final transfer, release the bus
  } dpStrobe_t;

  localparam logic [3:0] CMD_RD = 4'b0110;
  localparam logic [3:0] CMD_WR = 4'b0111;
endpackage

// File: rtl/busTgtCtrl.sv
module busTgtCtrl
  import busTgtPkg::*;
#(
  parameter int AW = 32,
  parameter int WIN_BITS = 8,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [AW-1:WIN_BITS]   adHi,
  input  logic [3:0]             cbeN,
  input  logic                   frameN,
  input  logic                   irdyN,
  input  logic [1:0]             devSpeed,
  input  logic                   locWait,
  input  logic                   isRd,
  output logic                   devselN,
  output logic                   trdyN,
  output logic                   busOe,
  output dpStrobe_t              strobe
);
  tgtState_e state;
  logic       prevFrameN;
  logic [1:0] cnt;
  logic [1:0] dly;
  logic       addrPhase, hit, xfer, lastXfer, trdyNext;

  always_comb begin
    unique case (devSpeed)
      2'd0:    dly = 2'd1;
      2'd1:    dly = 2'd2;
      default: dly = 2'd3;
    endcase
  end

  assign addrPhase = (state == ST_IDLE) && !frameN && prevFrameN;
  assign hit       = (adHi == BASE_ADDR[AW-1:WIN_BITS]) && (cbeN == CMD_RD || cbeN == CMD_WR);
  assign xfer      = (state == ST_DATA) && !trdyN && !irdyN;
  assign lastXfer  = xfer && frameN;

  always_comb begin
    if (trdyN) trdyNext = !(!devselN && !locWait);
    else       trdyNext = xfer ? locWait : 1'b0;
  end

  always_comb begin
    strobe.latch  = addrPhase && hit;
    strobe.inc    = xfer;
    strobe.dropAd = lastXfer;
    strobe.loadRd = isRd && (state == ST_DATA) && !lastXfer && !trdyNext && (trdyN || xfer);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      devselN    <= 1'b1;
      trdyN      <= 1'b1;
      busOe      <= 1'b0;
      prevFrameN <= 1'b1;
      cnt        <= 2'd0;
    end else begin
      prevFrameN <= frameN;
      unique case (state)
        ST_IDLE: if (addrPhase && hit) begin
          busOe <= 1'b1;
          if (dly == 2'd1) begin
            devselN <= 1'b0;
            state   <= ST_DATA;
          end else begin
            cnt   <= dly - 2'd1;
            state <= ST_CLAIM;
          end
        end
        ST_CLAIM: if (cnt == 2'd1) begin
          devselN <= 1'b0;
          state   <= ST_DATA;
        end else begin
          cnt <= cnt - 2'd1;
        end
        ST_DATA: if (lastXfer) begin
          devselN <= 1'b1;
          trdyN   <= 1'b1;
          state   <= ST_PARK;
        end else begin
          trdyN <= trdyNext;
        end
        ST_PARK: begin
          busOe <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  trdy_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && !trdyN && irdyN) |=> !trdyN);
  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trdyN && locWait) |=> trdyN);
  // R4
  trdy_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);
  // R9
  park_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOe) |-> ($past(devselN) && $past(trdyN)));
endmodule

// File: rtl/busTgtDpath.sv
module busTgtDpath
  import busTgtPkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] adIn,
  input  logic [BW-1:0] cbeN,
  input  logic [DW-1:0] locRdData,
  output logic          isRd,
  output logic [DW-1:0] adOut,
  output logic          adOe,
  output logic [AW-1:0] locAddr,
  output logic [DW-1:0] locWrData,
  output logic [BW-1:0] locBe,
  output logic          locWrEn
);
  localparam logic [AW-1:0] STEP = AW'(BW);
  logic [AW-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      isRd  <= 1'b0;
      adOut <= '0;
      adOe  <= 1'b0;
    end else begin
      if (strobe.latch) begin
        addrQ <= {adIn[AW-1:2], 2'b00};
        isRd  <= (cbeN == CMD_RD);
      end else if (strobe.inc) begin
        addrQ <= addrQ + STEP;
      end
      if (strobe.loadRd) adOut <= locRdData;
      if (strobe.dropAd)      adOe <= 1'b0;
      else if (strobe.loadRd) adOe <= 1'b1;
    end
  end

  assign locAddr   = (isRd && strobe.inc) ? addrQ + STEP : addrQ;
  assign locWrData = adIn[DW-1:0];
  assign locBe     = ~cbeN;
  assign locWrEn   = strobe.inc && !isRd;

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.latch) |=> (addrQ == $past(addrQ) + STEP));
endmodule

// File: rtl/busTgtTop.sv
module busTgtTop
  import busTgtPkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = DW / 8,
  parameter int WIN_BITS = 8,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    devSpeed,
  input  logic [AW-1:0] adIn,
  input  logic [BW-1:0] cbeN,
  input  logic          frameN,
  input  logic          irdyN,
  output logic [DW-1:0] adOut,
  output logic          adOe,
  output logic          devselN,
  output logic          devselOe,
  output logic          trdyN,
  output logic          trdyOe,
  output logic [AW-1:0] locAddr,
  output logic [DW-1:0] locWrData,
  output logic [BW-1:0] locBe,
  output logic          locWrEn,
  input  logic [DW-1:0] locRdData,
  input  logic          locWait
);
  dpStrobe_t strobe;
  logic      isRd, busOe;

  busTgtCtrl #(.AW(AW), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .adHi(adIn[AW-1:WIN_BITS]), .cbeN(cbeN),
    .frameN(frameN), .irdyN(irdyN), .devSpeed(devSpeed), .locWait(locWait),
    .isRd(isRd), .devselN(devselN), .trdyN(trdyN), .busOe(busOe), .strobe(strobe)
  );

  busTgtDpath #(.AW(AW), .DW(DW), .BW(BW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adIn(adIn), .cbeN(cbeN),
    .locRdData(locRdData), .isRd(isRd), .adOut(adOut), .adOe(adOe),
    .locAddr(locAddr), .locWrData(locWrData), .locBe(locBe), .locWrEn(locWrEn)
  );

  assign devselOe = busOe;
  assign trdyOe   = busOe;

  // R6
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && isRd) |-> adOe);
  // R6
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && irdyN && isRd) |=> $stable(adOut));
  // R8
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    locWrEn |-> (!trdyN && !irdyN && !devselN));
endmodule

// File: tb/busTgtTop_bench.sv
module busTgtTop_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  devSpeed;
  logic [31:0] adIn;
  logic [3:0]  cbeN;
  logic        frameN, irdyN, locWait;
  logic [31:0] adOut, locAddr, locWrData, locRdData;
  logic        adOe, devselN, devselOe, trdyN, trdyOe, locWrEn;
  logic [3:0]  locBe;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  busTgtTop u_busTgtTop (
    .clk(clk), .rstN(rstN), .devSpeed(devSpeed), .adIn(adIn), .cbeN(cbeN),
    .frameN(frameN), .irdyN(irdyN), .adOut(adOut), .adOe(adOe),
    .devselN(devselN), .devselOe(devselOe), .trdyN(trdyN), .trdyOe(trdyOe),
    .locAddr(locAddr), .locWrData(locWrData), .locBe(locBe), .locWrEn(locWrEn),
    .locRdData(locRdData), .locWait(locWait)
  );

  function automatic logic [31:0] rdPat(logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction
  function automatic logic [31:0] wdPat(logic [31:0] b, int ph);
    return b * 32'd7 + 32'(ph) * 32'd13;
  endfunction
  function automatic logic [3:0] bePat(int ph);
    return 4'hF >> ph;
  endfunction

  assign locRdData = rdPat(locAddr);

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameN = 1'b1; irdyN = 1'b1; adIn = '0; cbeN = 4'hF; locWait = 1'b0;
    end
  endtask

  task automatic runTxn(int spd, bit rd, int len, int w, int ii, bit late, logic [31:0] base);
    int d, tf, firstX, lastX, ph;
    bit irdyOn, inX;
    d = (spd > 2 ? 3 : spd + 1);
    tf = ((d > w + 1) ? d : w + 1) + 1;
    firstX = (tf > ii) ? tf : ii;
    lastX = firstX + len - 1;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = base; cbeN = rd ? 4'b0110 : 4'b0111;
    devSpeed = 2'(spd); locWait = 1'b0;
    for (int cyc = 1; cyc <= lastX + 2; cyc++) begin
      @(negedge clk);
      ph = (cyc < firstX) ? 0 : cyc - firstX;
      irdyOn = (cyc >= ii) && (cyc <= lastX);
      inX = (cyc >= firstX) && (cyc <= lastX);
      irdyN = !irdyOn;
      frameN = (cyc > lastX) ? 1'b1 : (irdyOn && ph == len - 1);
      locWait = (cyc <= w) || (late && (cyc == tf || cyc == tf + 1));
      adIn = rd ? 32'h0 : wdPat(base, ph);
      cbeN = ~bePat(ph);
      #1;
      // R2 claim delay and hold, R9 release
      chk(devselN == !(cyc >= d && cyc <= lastX), "R2", "devselN", 32'(devselN), 32'(!(cyc >= d && cyc <= lastX)));
      chk(devselOe == (cyc <= lastX + 1), "R9", "devselOe", 32'(devselOe), 32'(cyc <= lastX + 1));
      chk(trdyOe == (cyc <= lastX + 1), "R9", "trdyOe", 32'(trdyOe), 32'(cyc <= lastX + 1));
      // R4 first ready, R5 lock during late wait, R10 early wait
      chk(trdyN == !(cyc >= tf && cyc <= lastX), (late && cyc >= tf && cyc <= tf + 1) ? "R5" : "R4_R10",
          "trdyN", 32'(trdyN), 32'(!(cyc >= tf && cyc <= lastX)));
      if (rd) begin
        // R6 turnaround and drive window
        chk(adOe == (cyc >= tf && cyc <= lastX), "R6", "adOe", 32'(adOe), 32'(cyc >= tf && cyc <= lastX));
        if (inX || (cyc >= tf && cyc < firstX))
          chk(adOut == rdPat(base + 32'(4 * ph)), "R7", "adOut", adOut, rdPat(base + 32'(4 * ph)));
      end else begin
        chk(locWrEn == inX, "R8", "locWrEn", 32'(locWrEn), 32'(inX));
        if (inX) begin
          chk(locAddr == base + 32'(4 * ph), "R7", "locAddr", locAddr, base + 32'(4 * ph));
          chk(locWrData == wdPat(base, ph), "R8", "locWrData", locWrData, wdPat(base, ph));
          chk(locBe == bePat(ph), "R8", "locBe", 32'(locBe), 32'(bePat(ph)));
        end
      end
    end
    idle(2);
  endtask

  task automatic noClaim(logic [3:0] cmd, logic [31:0] a);
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = a; cbeN = cmd; devSpeed = 2'd0; locWait = 1'b0;
    for (int cyc = 1; cyc <= 5; cyc++) begin
      @(negedge clk);
      frameN = 1'b1; irdyN = (cyc > 4); adIn = '0; cbeN = 4'h0;
      #1;
      // R3
      chk(devselN && !devselOe && trdyN, "R3", "no claim", {devselN, devselOe, trdyN}, 32'b101);
    end
    idle(2);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; adIn = '0; cbeN = 4'hF;
    devSpeed = 2'd0; locWait = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(devselN && trdyN && !devselOe && !trdyOe && !adOe && !locWrEn, "R1", "reset outputs",
        {devselN, trdyN, devselOe, trdyOe, adOe, locWrEn}, 32'b110000);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk(devselN && trdyN && !devselOe && !adOe, "R1", "after reset", {devselN, trdyN, devselOe, adOe}, 32'b1100);
    idle(2);
    for (int spd = 0; spd < 4; spd++)
      for (int rd = 0; rd < 2; rd++)
        for (int len = 1; len <= 3; len++)
          for (int w = 0; w <= 2; w += 2)
            for (int ii = 1; ii <= 7; ii += 6)
              runTxn(spd, bit'(rd), len, w, ii, ii == 7, 32'h4000_0010 + 32'(spd * 32 + len * 4));
    noClaim(4'b1101, 32'h4000_0020); // dual-address
    noClaim(4'b0010, 32'h4000_0020); // other command
    noClaim(4'b0110, 32'h4000_0120); // outside window
    noClaim(4'b0111, 32'h5000_0000); // outside window
    runTxn(1, 1'b1, 2, 0, 1, 1'b0, 32'h4000_00F0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule